// File: doc/BRIEF.md
# Serial Multiply Coprocessor

This unit sits beside a host processor on an instruction-offload port. The host raises a request when it meets an instruction it does not execute itself. With the request it presents the 32-bit instruction word and the values of the two source registers. The unit picks out the four integer multiply instructions. These are the low word of the product, and the high word for signed by signed, signed by unsigned and unsigned by unsigned operands. It computes them with a shift-and-add engine that handles one multiplier bit per clock.

While it works, the unit holds a wait flag so that the host does not treat the instruction as unclaimed. The host would otherwise do so after 16 cycles. On completion the unit pulses ready and write for one cycle, with the 32-bit result beside them. The host then stores that result in the instruction's destination register. A low-word multiply takes 32 iterations and a high-word multiply takes 64. This gives roughly 33 and 65 cycles from request to completion.

Top module: `mul_offload_unit`

## Requirements
- R1: While the synchronous active-high reset is held, and in the cycle after it is released, rsp_wait, rsp_ready and rsp_write are low and rsp_data is zero.
- R2: An instruction is claimed only if all three fields match: bits [6:0] are 0110011, bits [31:25] are 0000001, and bits [14:12] are in the range 000 to 011. Any other word leaves rsp_wait and rsp_ready low for as long as it is presented.
- R3: An idle unit that samples req_valid with a claimed word raises rsp_wait in the next cycle. rsp_wait stays high in every cycle until the ready cycle. It is low in the ready cycle, and rsp_wait and rsp_ready are never high together.
- R4: Call the cycle in which the idle unit first samples the request cycle 0. rsp_ready is high in cycle 33 when bits [14:12] are 000, and in cycle 65 for the other three claimed codes.
- R5: Code 000 returns the low 32 bits of rs1 times rs2.
- R6: Code 001 returns the high 32 bits of the signed rs1 times the signed rs2.
- R7: Code 010 returns the high 32 bits of the signed rs1 times the unsigned rs2.
- R8: Code 011 returns the high 32 bits of the unsigned rs1 times the unsigned rs2.
- R9: rsp_ready and rsp_write are high together for exactly one cycle, and rsp_data carries the result in that cycle.
- R10: If req_valid stays high after the ready cycle, the instruction is not executed again. A new request is taken only after req_valid has been low for at least one cycle.
- R11: The instruction word and operands are captured at acceptance. Changes on req_insn, req_rs1 or req_rs2 while the unit is busy do not change the result.
- R12: A reset during a computation abandons it, and no ready pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers an instruction |
| req_insn | input | 32 | Instruction word |
| req_rs1 | input | 32 | First source operand |
| req_rs2 | input | 32 | Second source operand |
| rsp_wait | output | 1 | Instruction claimed, computation in progress |
| rsp_ready | output | 1 | Completion pulse |
| rsp_write | output | 1 | Result is to be written to the destination register |
| rsp_data | output | 32 | Result word |

## Verification
The hardest cases to reach are the ones where the host does not behave politely. In one, the host keeps req_valid high after completion. In another, it alters the operands and instruction word mid-computation. In a third, reset lands while the shift-and-add engine is partway through its count. The bench reaches these by holding or changing its inputs at chosen cycle offsets from acceptance. For each of these three cases it then checks that no second ready pulse, corrupted result or late ready appears. The arithmetic itself is swept over every pairing of eight edge-case operands for all four codes.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
  // funct3 low bits select the variant; the encoding order is decoded directly
  typedef enum logic [1:0] {
    OP_LO  = 2'd0,
    OP_HSS = 2'd1,
    OP_HSU = 2'd2,
    OP_HUU = 2'd3
  } mulu_op_e;

  function automatic logic a_is_signed(mulu_op_e op);
    return (op != OP_HUU);
  endfunction

  function automatic logic b_is_signed(mulu_op_e op);
    return (op == OP_LO) || (op == OP_HSS);
  endfunction
endpackage

// File: rtl/mulu_decode.sv
module mulu_decode
  import mulu_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] insn,
  output logic          hit,
  output mulu_op_e      op
);
  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] F7_MUL  = 7'b0000001;

  always_comb begin
    hit = (insn[6:0] == OPC_REG) && (insn[31:25] == F7_MUL) && !insn[14];
    op  = mulu_op_e'(insn[13:12]);
  end
endmodule

// File: rtl/mulu_shift_add.sv
module mulu_shift_add #(
  parameter int PW = 64
) (
  input  logic          clk,
  input  logic          load,
  input  logic          step,
  input  logic [PW-1:0] a_ext,
  input  logic [PW-1:0] b_ext,
  output logic [PW-1:0] acc_nxt
);
  logic [PW-1:0] mcand;
  logic [PW-1:0] mplier;
  logic [PW-1:0] acc;

  always_comb acc_nxt = acc + (mplier[0] ? mcand : '0);

  always_ff @(posedge clk) begin
    if (load) begin
      mcand  <= a_ext;
      mplier <= b_ext;
      acc    <= '0;
    end else if (step) begin
      acc    <= acc_nxt;
      mcand  <= {mcand[PW-2:0], 1'b0};
      mplier <= {1'b0, mplier[PW-1:1]};
    end
  end
endmodule

// File: rtl/mul_offload_unit.sv
module mul_offload_unit
  import mulu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [31:0]     req_insn,
  input  logic [XLEN-1:0] req_rs1,
  input  logic [XLEN-1:0] req_rs2,
  output logic            rsp_wait,
  output logic            rsp_ready,
  output logic            rsp_write,
  output logic [XLEN-1:0] rsp_data
);
  localparam int PW = 2 * XLEN;
  localparam int CW = $clog2(PW + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE, ST_HOLD} st_e;

  st_e           state;
  logic [CW-1:0] cnt;
  mulu_op_e      op_q;
  logic          dec_hit;
  mulu_op_e      dec_op;
  logic          accept;
  logic [PW-1:0] a_ext, b_ext, acc_nxt;

  mulu_decode #(.IW(32)) u_dec (
    .insn(req_insn), .hit(dec_hit), .op(dec_op)
  );

  always_comb begin
    accept = (state == ST_IDLE) && req_valid && dec_hit;
    a_ext  = {{XLEN{a_is_signed(dec_op) & req_rs1[XLEN-1]}}, req_rs1};
    b_ext  = {{XLEN{b_is_signed(dec_op) & req_rs2[XLEN-1]}}, req_rs2};
  end

  mulu_shift_add #(.PW(PW)) u_dp (
    .clk(clk), .load(accept), .step(state == ST_RUN),
    .a_ext(a_ext), .b_ext(b_ext), .acc_nxt(acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      op_q      <= OP_LO;
      rsp_wait  <= 1'b0;
      rsp_ready <= 1'b0;
      rsp_write <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_ready <= 1'b0;
      rsp_write <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_RUN;
          op_q     <= dec_op;
          cnt      <= (dec_op == OP_LO) ? CW'(XLEN) : CW'(PW);
          rsp_wait <= 1'b1;
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            state     <= ST_DONE;
            rsp_wait  <= 1'b0;
            rsp_ready <= 1'b1;
            rsp_write <= 1'b1;
            rsp_data  <= (op_q == OP_LO) ? acc_nxt[XLEN-1:0] : acc_nxt[PW-1:XLEN];
          end
        end
        ST_DONE: state <= req_valid ? ST_HOLD : ST_IDLE;
        default: if (!req_valid) state <= ST_IDLE;
      endcase
    end
  end

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready); // R9
  AST_READY_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> $past(rsp_wait)); // R3
  AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !(rsp_wait && rsp_ready)); // R3
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
    (rsp_ready && req_valid) |=> !rsp_wait); // R10
  AST_WAIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_wait) |-> $past(req_valid)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(PW)); // R4
endmodule

// File: tb/mul_offload_unit_bench.sv
module mul_offload_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_insn = '0, req_rs1 = '0, req_rs2 = '0;
  logic        rsp_wait, rsp_ready, rsp_write;
  logic [31:0] rsp_data;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_offload_unit u_mul_offload_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_insn(req_insn),
    .req_rs1(req_rs1), .req_rs2(req_rs2), .rsp_wait(rsp_wait),
    .rsp_ready(rsp_ready), .rsp_write(rsp_write), .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(logic [2:0] f3);
    return {7'b0000001, 5'd3, 5'd2, f3, 5'd1, 7'b0110011};
  endfunction

  function automatic logic [31:0] expect_val(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    logic [63:0] ea, eb, p;
    ea = {{32{(op != 2'd3) & a[31]}}, a};
    eb = {{32{(op == 2'd1) & b[31]}}, b};
    p  = ea * eb;
    return (op == 2'd0) ? p[31:0] : p[63:32];
  endfunction

  function automatic logic [31:0] opnd(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h1234_5678;
      6: return 32'hDEAD_BEEF;
      default: return 32'hFFFF_0003;
    endcase
  endfunction

  // Runs one op; perturb=1 scrambles inputs after acceptance (R11)
  task automatic run_op(logic [1:0] op, logic [31:0] a, logic [31:0] b, bit perturb);
    int n = 0;
    int lim = (op == 2'd0) ? 33 : 65;
    bit wait_ok = 1'b1;
    logic [31:0] exp = expect_val(op, a, b);
    @(negedge clk);
    req_valid = 1'b1; req_insn = mk_insn({1'b0, op}); req_rs1 = a; req_rs2 = b;
    while (n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (perturb && n == 1) begin
        req_rs1 = ~a; req_rs2 = b ^ 32'h5A5A_0F0F; req_insn = mk_insn(3'b000 ^ {1'b0, ~op});
      end
      if (rsp_ready) break;
      if (!rsp_wait) wait_ok = 1'b0;
    end
    check(wait_ok, "R3 wait held until ready", {63'd0, wait_ok}, 64'd1);
    check(n == lim, "R4 latency", n, lim);
    check(rsp_write && !rsp_wait, "R9 write with ready", {rsp_write, rsp_wait}, 2'b10);
    case (op)
      2'd0: check(rsp_data == exp, perturb ? "R11 R5 MUL" : "R5 MUL", rsp_data, exp);
      2'd1: check(rsp_data == exp, perturb ? "R11 R6 MULH" : "R6 MULH", rsp_data, exp);
      2'd2: check(rsp_data == exp, "R7 MULHSU", rsp_data, exp);
      default: check(rsp_data == exp, "R8 MULHU", rsp_data, exp);
    endcase
    // valid still high: no re-execution (R10), single pulse (R9)
    req_insn = mk_insn({1'b0, op});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!rsp_ready && !rsp_wait, "R10 R9 no refire", {rsp_ready, rsp_wait}, 2'b00);
    end
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({rsp_wait, rsp_ready, rsp_write} == 3'b000 && rsp_data == 0, "R1 in reset",
          {rsp_wait, rsp_ready, rsp_write, rsp_data}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check({rsp_wait, rsp_ready, rsp_write} == 3'b000 && rsp_data == 0, "R1 after reset",
          {rsp_wait, rsp_ready, rsp_write, rsp_data}, 64'd0);

    // R2: non-claimed words held
    for (int w = 0; w < 6; w++) begin
      bit seen = 1'b0;
      case (w)
        0: req_insn = mk_insn(3'b100);
        1: req_insn = mk_insn(3'b111);
        2: req_insn = mk_insn(3'b000) ^ 32'h0000_0040;
        3: req_insn = mk_insn(3'b001) ^ 32'h0200_0000;
        4: req_insn = mk_insn(3'b010) | 32'h4000_0000;
        default: req_insn = 32'h0000_0013;
      endcase
      req_rs1 = 32'd7; req_rs2 = 32'd9; req_valid = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (rsp_wait || rsp_ready) seen = 1'b1;
      end
      check(!seen, "R2 unclaimed ignored", {63'd0, seen}, 64'd0);
      req_valid = 1'b0;
      @(negedge clk);
    end

    // R5..R8 sweep
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(op[1:0], opnd(i), opnd(j), 1'b0);

    // R11 perturbation
    run_op(2'd0, 32'hDEAD_BEEF, 32'h1234_5678, 1'b1);
    run_op(2'd1, 32'h8000_0001, 32'hFFFF_FFF0, 1'b1);

    // R12 reset mid-computation
    begin
      bit late = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_insn = mk_insn(3'b011); req_rs1 = 32'hFFFF_FFFF; req_rs2 = 32'h3;
      repeat (10) @(negedge clk);
      rst = 1'b1; req_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (rsp_ready || rsp_wait) late = 1'b1;
      end
      check(!late, "R12 abort on reset", {63'd0, late}, 64'd0);
      run_op(2'd3, 32'hFFFF_FFFF, 32'h3, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule